// File: doc/BRIEF.md
# Frequency-Tracking Clock Source Selector

This block keeps track of a clock path as a number. It does not switch a real clock. It holds four settings: a selected source index, an enable, a multiplier and a divider. From a bank of source frequency words it derives an output frequency word, which is the selected source's value times the multiplier, divided by the divider, using integer arithmetic. When the block is disabled, or when the divider is zero, the output word is zero.

Three kinds of command change the settings: select a source, set the enable, and set the factor (multiplier and divider together). Each command arrives with a one-cycle valid pulse. A command that leaves every setting unchanged is dropped. Each source also has a change strobe. A strobe from the selected source makes the block recompute with that source's current word. A strobe from any other source is ignored.

The division runs in a bit-serial divider. While a computation is in flight, a busy output is high. Commands that arrive during that time are parked and applied as soon as the block goes idle. Every new result is announced by a one-cycle update strobe.

Top module: `freq_sel_track`

## Requirements
- R1: After reset, `freq_o` is 0, `upd_o` is 0 and `busy_o` is 0. The internal settings are: disabled, source 0, multiplier 1, divider 1.
- R2: When enabled with a nonzero divider, a result equals floor(source word × multiplier / divider). The source word and factors are taken in the cycle the computation starts. `freq_o` and `upd_o` change FREQ_W+FAC_W+1 clock edges after the edge that accepted the triggering command (49 edges with the defaults).
- R3: When the enable is 0 or the divider is 0, the result is 0. It appears one clock edge after the accepting edge, and the divider is not used.
- R4: A quotient that does not fit in FREQ_W bits saturates `freq_o` to all ones.
- R5: A command whose value equals the current setting is ignored. `busy_o` stays 0, `upd_o` stays 0 and `freq_o` is unchanged. A factor command counts as a change if either its multiplier or its divider differs.
- R6: A pulse on `src_chg_i[k]` starts a recomputation with the current word of source k only when k is the selected source. Pulses on other sources are ignored.
- R7: `upd_o` is high for exactly one cycle: the first cycle in which `freq_o` shows a new result. `freq_o` never changes without `upd_o`.
- R8: `busy_o` is high from the edge that starts a computation until the update cycle has ended. Commands received while busy are held, with the latest value of each kind winning. A change strobe from the selected source that arrives while busy is held too. All held items are applied together in one further computation once the block is idle.
- R9: Source k's frequency word sits in bits [k×FREQ_W +: FREQ_W] of `src_freq_i`. The value on `set_src_i` is the source index k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_freq_i | input | NUM_SRC*FREQ_W | Packed source frequency words, source k at k*FREQ_W |
| src_chg_i | input | NUM_SRC | Per-source change strobe |
| set_src_vld_i | input | 1 | Source select command valid |
| set_src_i | input | SEL_W | Requested source index |
| set_en_vld_i | input | 1 | Enable command valid |
| set_en_i | input | 1 | Requested enable |
| set_fac_vld_i | input | 1 | Factor command valid |
| set_mul_i | input | FAC_W | Requested multiplier |
| set_div_i | input | FAC_W | Requested divider |
| freq_o | output | FREQ_W | Registered output frequency word |
| upd_o | output | 1 | One-cycle strobe marking a new result |
| busy_o | output | 1 | Computation in flight; commands are held |

## Verification
A full divide lands FREQ_W+FAC_W+1 edges after the accepting edge, and a forced-zero result lands one edge after it. The bench counts falling edges from the release of each command pulse and compares that count with 50 or 2. It samples at the falling edge in which `upd_o` is first seen, then one edge later, where both `upd_o` and `busy_o` must be low. The tests for held commands and for a strobe arriving while busy wait for two successive update strobes and check both values. The tests for ignored stimulus watch the ports for several cycles and expect no activity.

// File: rtl/fst_pkg.sv
package fst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_NOTE = 2'd2
    } fst_state_e;
endpackage

// File: rtl/fst_cmd_hold.sv
module fst_cmd_hold #(
    parameter int SEL_W = 3,
    parameter int FAC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy_i,
    input  logic             src_vld_i,
    input  logic [SEL_W-1:0] src_i,
    input  logic             en_vld_i,
    input  logic             en_i,
    input  logic             fac_vld_i,
    input  logic [FAC_W-1:0] mul_i,
    input  logic [FAC_W-1:0] div_i,
    output logic             src_vld_o,
    output logic [SEL_W-1:0] src_o,
    output logic             en_vld_o,
    output logic             en_o,
    output logic             fac_vld_o,
    output logic [FAC_W-1:0] mul_o,
    output logic [FAC_W-1:0] div_o
);
    typedef struct packed {
        logic             src_p;
        logic [SEL_W-1:0] src_v;
        logic             en_p;
        logic             en_v;
        logic             fac_p;
        logic [FAC_W-1:0] mul_v;
        logic [FAC_W-1:0] div_v;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (busy_i) begin
            if (src_vld_i) begin
                h_d.src_p = 1'b1;
                h_d.src_v = src_i;
            end
            if (en_vld_i) begin
                h_d.en_p = 1'b1;
                h_d.en_v = en_i;
            end
            if (fac_vld_i) begin
                h_d.fac_p = 1'b1;
                h_d.mul_v = mul_i;
                h_d.div_v = div_i;
            end
        end else begin
            h_d.src_p = 1'b0;
            h_d.en_p  = 1'b0;
            h_d.fac_p = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign src_vld_o = src_vld_i | h_q.src_p;
    assign src_o     = src_vld_i ? src_i : h_q.src_v;
    assign en_vld_o  = en_vld_i | h_q.en_p;
    assign en_o      = en_vld_i ? en_i : h_q.en_v;
    assign fac_vld_o = fac_vld_i | h_q.fac_p;
    assign mul_o     = fac_vld_i ? mul_i : h_q.mul_v;
    assign div_o     = fac_vld_i ? div_i : h_q.div_v;

    // R8: a command seen while busy is still offered on the next cycle
    a_r8_src_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && src_vld_i) |=> src_vld_o);
    a_r8_fac_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && fac_vld_i) |=> fac_vld_o);
endmodule

// File: rtl/fst_seqdiv.sv
module fst_seqdiv #(
    parameter int DVD_W = 48,
    parameter int DVS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DVD_W-1:0] dvd_i,
    input  logic [DVS_W-1:0] dvs_i,
    output logic             busy_o,
    output logic [DVD_W-1:0] quo_o
);
    localparam int CNT_W = $clog2(DVD_W + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [DVS_W:0]   rem;
        logic [DVD_W-1:0] quo;
        logic [DVS_W-1:0] dvs;
    } div_t;

    div_t d_d, d_q;
    logic [DVS_W:0] rem_sh;
    logic           fits;

    always_comb begin
        d_d    = d_q;
        rem_sh = {d_q.rem[DVS_W-1:0], d_q.quo[DVD_W-1]};
        fits   = rem_sh >= {1'b0, d_q.dvs};
        if (start_i) begin
            d_d.cnt = CNT_W'(DVD_W);
            d_d.rem = '0;
            d_d.quo = dvd_i;
            d_d.dvs = dvs_i;
        end else if (d_q.cnt != '0) begin
            d_d.rem = fits ? (rem_sh - {1'b0, d_q.dvs}) : rem_sh;
            d_d.quo = {d_q.quo[DVD_W-2:0], fits};
            d_d.cnt = d_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign busy_o = (d_q.cnt != '0);
    assign quo_o  = d_q.quo;

    // R2: the final remainder is below the divisor
    a_r2_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (d_q.cnt == CNT_W'(1) && !start_i) |=> (d_q.rem < {1'b0, d_q.dvs}));
    // R8: a new division never starts on top of a running one
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);
endmodule

// File: rtl/freq_sel_track.sv
module freq_sel_track #(
    parameter int NUM_SRC = 8,
    parameter int FREQ_W  = 32,
    parameter int FAC_W   = 16,
    localparam int SEL_W  = $clog2(NUM_SRC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC*FREQ_W-1:0] src_freq_i,
    input  logic [NUM_SRC-1:0]        src_chg_i,
    input  logic                      set_src_vld_i,
    input  logic [SEL_W-1:0]          set_src_i,
    input  logic                      set_en_vld_i,
    input  logic                      set_en_i,
    input  logic                      set_fac_vld_i,
    input  logic [FAC_W-1:0]          set_mul_i,
    input  logic [FAC_W-1:0]          set_div_i,
    output logic [FREQ_W-1:0]         freq_o,
    output logic                      upd_o,
    output logic                      busy_o
);
    import fst_pkg::*;

    localparam int PROD_W = FREQ_W + FAC_W;

    typedef struct packed {
        fst_state_e       state;
        logic [SEL_W-1:0] src;
        logic             en;
        logic [FAC_W-1:0] mul;
        logic [FAC_W-1:0] dv;
        logic             zero;
        logic             redo;
        logic [FREQ_W-1:0] freq;
    } core_t;

    core_t c_d, c_q;

    logic             h_src_vld, h_en_vld, h_fac_vld, h_en;
    logic [SEL_W-1:0] h_src;
    logic [FAC_W-1:0] h_mul, h_div;

    logic              div_start, div_busy;
    logic [PROD_W-1:0] div_dvd, div_quo;

    logic [SEL_W-1:0]  n_src;
    logic              n_en;
    logic [FAC_W-1:0]  n_mul, n_dv;
    logic              cfg_chg, sel_chg, n_zero;
    logic [FREQ_W-1:0] sel_f, sat_q;

    fst_cmd_hold #(.SEL_W(SEL_W), .FAC_W(FAC_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy_i    (busy_o),
        .src_vld_i (set_src_vld_i),
        .src_i     (set_src_i),
        .en_vld_i  (set_en_vld_i),
        .en_i      (set_en_i),
        .fac_vld_i (set_fac_vld_i),
        .mul_i     (set_mul_i),
        .div_i     (set_div_i),
        .src_vld_o (h_src_vld),
        .src_o     (h_src),
        .en_vld_o  (h_en_vld),
        .en_o      (h_en),
        .fac_vld_o (h_fac_vld),
        .mul_o     (h_mul),
        .div_o     (h_div)
    );

    fst_seqdiv #(.DVD_W(PROD_W), .DVS_W(FAC_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_start),
        .dvd_i   (div_dvd),
        .dvs_i   (n_dv),
        .busy_o  (div_busy),
        .quo_o   (div_quo)
    );

    always_comb begin
        c_d       = c_q;
        div_start = 1'b0;

        n_src   = h_src_vld ? h_src : c_q.src;
        n_en    = h_en_vld  ? h_en  : c_q.en;
        n_mul   = h_fac_vld ? h_mul : c_q.mul;
        n_dv    = h_fac_vld ? h_div : c_q.dv;
        cfg_chg = (n_src != c_q.src) || (n_en != c_q.en) ||
                  (n_mul != c_q.mul) || (n_dv != c_q.dv);
        sel_chg = src_chg_i[c_q.src];
        n_zero  = !n_en || (n_dv == '0);
        sel_f   = src_freq_i[int'(n_src)*FREQ_W +: FREQ_W];
        div_dvd = PROD_W'(sel_f) * PROD_W'(n_mul);
        sat_q   = (div_quo[PROD_W-1:FREQ_W] != '0) ? '1 : div_quo[FREQ_W-1:0];

        unique case (c_q.state)
            ST_IDLE: begin
                if (cfg_chg || sel_chg || c_q.redo) begin
                    c_d.src   = n_src;
                    c_d.en    = n_en;
                    c_d.mul   = n_mul;
                    c_d.dv    = n_dv;
                    c_d.zero  = n_zero;
                    c_d.redo  = 1'b0;
                    c_d.state = ST_CALC;
                    div_start = !n_zero;
                end
            end
            ST_CALC: begin
                if (sel_chg) c_d.redo = 1'b1;
                if (!div_busy) begin
                    c_d.freq  = c_q.zero ? '0 : sat_q;
                    c_d.state = ST_NOTE;
                end
            end
            ST_NOTE: begin
                if (sel_chg) c_d.redo = 1'b1;
                c_d.state = ST_IDLE;
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.state <= ST_IDLE;
            c_q.mul   <= FAC_W'(1);
            c_q.dv    <= FAC_W'(1);
        end else begin
            c_q <= c_d;
        end
    end

    assign freq_o = c_q.freq;
    assign upd_o  = (c_q.state == ST_NOTE);
    assign busy_o = (c_q.state != ST_IDLE);

    // R7: strobe lasts one cycle
    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o);
    // R7: the output word only moves together with the strobe
    a_r7_freq_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_o != $past(freq_o)) |-> upd_o);
    // R3: disabled or zero divider yields a zero result
    a_r3_forced_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_o && (!c_q.en || c_q.dv == '0)) |-> (freq_o == '0));
    // R8: the divider is only active during a busy period
    a_r8_div_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> busy_o);
endmodule

// File: tb/tb_freq_sel_track.sv
module tb_freq_sel_track;
    localparam int CLK_P     = 10;
    localparam int NSRC      = 8;
    localparam int FW        = 32;
    localparam int KW        = 16;
    localparam int LAT_FULL  = FW + KW + 2;
    localparam int LAT_ZERO  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC*FW-1:0] src_freq;
    logic [NSRC-1:0]   src_chg = '0;
    logic              s_vld = 1'b0, e_vld = 1'b0, f_vld = 1'b0;
    logic [2:0]        s_val = '0;
    logic              e_val = 1'b0;
    logic [KW-1:0]     m_val = '0, d_val = '0;
    logic [FW-1:0]     freq_o;
    logic              upd_o, busy_o;

    logic [FW-1:0] freqs [NSRC];
    int checks = 0;
    int fails  = 0;
    int cur_src = 0;
    bit cur_en  = 1'b0;
    longint cur_mul = 1, cur_div = 1;

    always #(CLK_P/2) clk = ~clk;

    always_comb begin
        for (int k = 0; k < NSRC; k++) src_freq[k*FW +: FW] = freqs[k];
    end

    freq_sel_track dut (
        .clk(clk), .rst_n(rst_n), .src_freq_i(src_freq), .src_chg_i(src_chg),
        .set_src_vld_i(s_vld), .set_src_i(s_val),
        .set_en_vld_i(e_vld), .set_en_i(e_val),
        .set_fac_vld_i(f_vld), .set_mul_i(m_val), .set_div_i(d_val),
        .freq_o(freq_o), .upd_o(upd_o), .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint model(input int s, input bit en, input longint m, input longint d);
        longint q;
        if (!en || d == 0) return 0;
        q = (longint'(freqs[s]) * m) / d;
        if (q > longint'(32'hFFFF_FFFF)) q = longint'(32'hFFFF_FFFF);
        return q;
    endfunction

    task automatic send_src(input int s);
        @(negedge clk); s_vld = 1'b1; s_val = 3'(s);
        @(negedge clk); s_vld = 1'b0;
    endtask
    task automatic send_en(input bit e);
        @(negedge clk); e_vld = 1'b1; e_val = e;
        @(negedge clk); e_vld = 1'b0;
    endtask
    task automatic send_fac(input longint m, input longint d);
        @(negedge clk); f_vld = 1'b1; m_val = KW'(m); d_val = KW'(d);
        @(negedge clk); f_vld = 1'b0;
    endtask

    task automatic wait_upd(output int n);
        n = 1;
        while (!upd_o && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic expect_result(input string req, input int lat_exp, input longint f_exp);
        int n;
        wait_upd(n);
        chk(n == lat_exp, {req, " latency"}, n, lat_exp);
        chk(longint'(freq_o) == f_exp, {req, " value"}, freq_o, f_exp);
        @(negedge clk);
        chk(!upd_o, "R7 strobe one cycle", upd_o, 0);
        chk(!busy_o, "R8 busy cleared after update", busy_o, 0);
    endtask

    task automatic quiet_window(input string req, input longint f_hold);
        int ups = 0, bz = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (upd_o) ups++;
            if (busy_o) bz++;
        end
        chk(ups == 0, {req, " no strobe"}, ups, 0);
        chk(bz == 0, {req, " no busy"}, bz, 0);
        chk(longint'(freq_o) == f_hold, {req, " output kept"}, freq_o, f_hold);
    endtask

    task automatic t_reset();
        chk(freq_o == '0, "R1 reset freq", freq_o, 0);
        chk(!upd_o, "R1 reset strobe", upd_o, 0);
        chk(!busy_o, "R1 reset busy", busy_o, 0);
    endtask

    task automatic t_enable();
        send_en(1'b1); cur_en = 1'b1;
        expect_result("R2 enable src0 x1/1", LAT_FULL, model(cur_src, cur_en, cur_mul, cur_div));
    endtask

    task automatic t_factor();
        send_fac(3, 7); cur_mul = 3; cur_div = 7;
        expect_result("R2 factor 3/7", LAT_FULL, model(cur_src, cur_en, cur_mul, cur_div));
    endtask

    task automatic t_select();
        send_src(5); cur_src = 5;
        expect_result("R9 select source 5", LAT_FULL, model(cur_src, cur_en, cur_mul, cur_div));
    endtask

    task automatic t_disable();
        send_en(1'b0); cur_en = 1'b0;
        expect_result("R3 disabled gives zero", LAT_ZERO, 0);
        send_en(1'b1); cur_en = 1'b1;
        expect_result("R2 re-enable", LAT_FULL, model(cur_src, cur_en, cur_mul, cur_div));
    endtask

    task automatic t_divzero();
        send_fac(4, 0); cur_mul = 4; cur_div = 0;
        expect_result("R3 zero divider gives zero", LAT_ZERO, 0);
        send_fac(5, 2); cur_mul = 5; cur_div = 2;
        expect_result("R2 factor 5/2", LAT_FULL, model(cur_src, cur_en, cur_mul, cur_div));
    endtask

    task automatic t_ignore();
        longint f = longint'(freq_o);
        send_src(cur_src);
        quiet_window("R5 same source", f);
        send_en(cur_en);
        quiet_window("R5 same enable", f);
        send_fac(cur_mul, cur_div);
        quiet_window("R5 same factor", f);
    endtask

    task automatic t_strobe();
        longint f = longint'(freq_o);
        @(negedge clk); freqs[2] = 32'd777_000; src_chg = 8'b0000_0100;
        @(negedge clk); src_chg = '0;
        quiet_window("R6 unselected strobe", f);
        @(negedge clk); freqs[cur_src] = 32'd90_000_001; src_chg[cur_src] = 1'b1;
        @(negedge clk); src_chg = '0;
        expect_result("R6 selected strobe", LAT_FULL, model(cur_src, cur_en, cur_mul, cur_div));
    endtask

    task automatic t_saturate();
        @(negedge clk); freqs[cur_src] = 32'hFFFF_FFFF; src_chg[cur_src] = 1'b1;
        @(negedge clk); src_chg = '0;
        expect_result("R6 strobe before saturation", LAT_FULL, model(cur_src, cur_en, cur_mul, cur_div));
        send_fac(16'hFFFF, 1); cur_mul = 16'hFFFF; cur_div = 1;
        expect_result("R4 saturated result", LAT_FULL, 32'hFFFF_FFFF);
    endtask

    task automatic t_hold();
        int n;
        longint first;
        send_fac(2, 1); cur_mul = 2; cur_div = 1;
        first = model(cur_src, cur_en, cur_mul, cur_div);
        chk(busy_o, "R8 busy during computation", busy_o, 1);
        send_src(1);
        send_src(6); cur_src = 6;
        wait_upd(n);
        chk(longint'(freq_o) == first, "R8 first result uses old source", freq_o, first);
        @(negedge clk);
        wait_upd(n);
        chk(longint'(freq_o) == model(6, cur_en, cur_mul, cur_div),
            "R8 held command latest wins", freq_o, model(6, cur_en, cur_mul, cur_div));
        @(negedge clk);
        chk(!busy_o, "R8 idle after held command", busy_o, 0);
    endtask

    task automatic t_redo();
        int n;
        longint first;
        send_fac(3, 2); cur_mul = 3; cur_div = 2;
        first = model(cur_src, cur_en, cur_mul, cur_div);
        @(negedge clk); freqs[cur_src] = 32'd50_000_000; src_chg[cur_src] = 1'b1;
        @(negedge clk); src_chg = '0;
        wait_upd(n);
        chk(longint'(freq_o) == first, "R8 value sampled at start", freq_o, first);
        @(negedge clk);
        wait_upd(n);
        chk(longint'(freq_o) == model(cur_src, cur_en, cur_mul, cur_div),
            "R8 held strobe recomputes", freq_o, model(cur_src, cur_en, cur_mul, cur_div));
        @(negedge clk);
        chk(!busy_o, "R8 idle after held strobe", busy_o, 0);
    endtask

    initial begin
        #(CLK_P * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < NSRC; k++) freqs[k] = 32'((k + 1) * 1_000_000 + k * 7);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_factor();
        t_select();
        t_disable();
        t_divzero();
        t_ignore();
        t_strobe();
        t_saturate();
        t_hold();
        t_redo();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule